// File: doc/BRIEF.md
# Configuration strap capture and polarity controller

This block sits next to the hub core and freezes the board-level configuration straps at the moment reset is released. It turns the captured straps into the configuration source, the SMBus slave address, a per-port mask of non-removable ports, and the active level of each port's power enable and indicator LED. The rest of the hub raises per-port power and LED requests; the block converts each request to the electrical level the board expects.

While reset is asserted, and until the capture has happened, the power enable outputs are held at the inactive level implied by the live polarity strap, so downstream power cannot come on during a reset. The LED outputs idle high in that window. All strap, local-supply and upstream VBUS inputs pass through a synchronizer into the core clock domain. The local-supply status follows its input continuously, and the upstream connect request follows the VBUS detect input once the configuration is valid.

Top module: `strap_capture_ctrl`

## Requirements
- R1: On the first core clock edge at which the synchronous active-low reset `rst_n` is high, the synchronized straps are captured and `cfg_valid_o` goes high; `cfg_valid_o` is low during reset.
- R2: While `rst_n` is low, and until the capture edge, every bit of `port_pwr_o` equals the inverse of the live `pwr_pol_strap_i` input, with no clock needed.
- R3: After capture, with captured polarity 1 each `port_pwr_o[i]` equals `port_pwr_req_i[i]` (active high); with captured polarity 0 it equals its inverse (active low).
- R4: The captured select code {sel1,sel0} is shown on `cfg_src_o` and decodes as 2'b00 reserved, 2'b01 SMBus slave, 2'b10 internal default from straps, 2'b11 serial EEPROM; exactly one of `mode_reserved_o`, `mode_smbus_o`, `mode_default_o`, `mode_eeprom_o` is high after capture, all are low before.
- R5: In SMBus slave mode `smbus_addr_o` is 7'b0101100; in every other mode it is zero.
- R6: In default mode `nonrem_o[i]` is high when the captured non-removable strap value, read as an unsigned number, is greater than i (00: none, 01: port 1, 10 and 11: ports 1 and 2); in other modes `nonrem_o` is zero.
- R7: In default mode LED i is active high when captured non-removable strap bit i is 0 and active low when it is 1; an active-high LED output equals `led_req_i[i]`, an active-low one equals its inverse.
- R8: In SMBus, EEPROM and reserved modes every LED is active low (`led_o` = ~`led_req_i`); before capture `led_o` is all ones.
- R9: `cfg_zero_fill_o` is high exactly when the captured mode is EEPROM and `eeprom_absent_i` is high.
- R10: `self_powered_o` follows `self_pwr_i` with a latency of SYNC_STAGES core clock edges, in and out of reset.
- R11: `connect_req_o` equals the synchronized `vbus_det_i` (SYNC_STAGES edges of latency) when `cfg_valid_o` is high, and is low otherwise.
- R12: Strap input changes after the capture edge have no effect on `cfg_src_o`, the mode outputs, `nonrem_o` or the applied polarities until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; its release triggers the capture |
| cfg_sel_strap_i | input | 2 | Configuration source straps {sel1, sel0} |
| nonrem_strap_i | input | NUM_PORTS | Non-removable / LED polarity straps |
| pwr_pol_strap_i | input | 1 | Port power enable polarity strap (1 = active high) |
| self_pwr_i | input | 1 | Local supply present |
| vbus_det_i | input | 1 | Upstream VBUS detect |
| eeprom_absent_i | input | 1 | EEPROM loader reports no device responded |
| port_pwr_req_i | input | NUM_PORTS | Per-port power-on requests |
| led_req_i | input | NUM_PORTS | Per-port LED-on requests |
| port_pwr_o | output | NUM_PORTS | Port power enables at the strapped level |
| led_o | output | NUM_PORTS | Port LED drives at the decoded level |
| cfg_valid_o | output | 1 | Straps captured |
| cfg_src_o | output | 2 | Captured select code |
| mode_smbus_o | output | 1 | SMBus slave configuration |
| mode_default_o | output | 1 | Internal default configuration |
| mode_eeprom_o | output | 1 | EEPROM configuration |
| mode_reserved_o | output | 1 | Reserved select code captured |
| smbus_addr_o | output | 7 | SMBus slave address in SMBus mode |
| nonrem_o | output | NUM_PORTS | Non-removable port mask |
| cfg_zero_fill_o | output | 1 | Load all configuration fields as zero |
| self_powered_o | output | 1 | Hub is self-powered |
| connect_req_o | output | 1 | Request for the upstream pull-up |

## Verification
The bench builds the block with NUM_PORTS = 2 and SYNC_STAGES = 2, which makes every one of the four non-removable strap codes, and so every LED polarity mix and each port mask, reachable from a reset. Two synchronizer stages make the capture edge and the status latency short enough to check cycle by cycle, including the value one edge before the change appears. Each select code and both power polarities are captured from separate resets, and straps are then disturbed after capture to show they are ignored.

// File: rtl/strap_pkg.sv
// Package: shared types and constants for the strap capture controller.
// Assumes: the select code encoding is fixed by board strapping.
package strap_pkg;

    // Configuration source, encoded as the {sel1, sel0} strap pair.
    typedef enum logic [1:0] {
        CFG_RESERVED = 2'b00,
        CFG_SMBUS    = 2'b01,
        CFG_DEFAULT  = 2'b10,
        CFG_EEPROM   = 2'b11
    } cfg_src_e;

    // Slave address reported while SMBus configuration is selected.
    localparam logic [6:0] SMBUS_SLAVE_ADDR = 7'b0101100;

    // Width of the select strap field.
    localparam int CFG_SEL_W = 2;

endpackage

// File: rtl/strap_sync.sv
// Module: strap_sync
// Moves a bundle of slow, level-type inputs into the core clock domain
// through a chain of STAGES flops. Assumes: each bit is quasi-static, so
// bits need not stay coherent with each other; the chain has no reset so
// it keeps tracking the inputs while the core is held in reset.
module strap_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        chain[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/strap_latch.sv
// Module: strap_latch
// Freezes the synchronized straps on the first clock edge after reset
// release and holds them until the next reset. Assumes: rst_n is
// synchronous to clk and the straps have settled through the synchronizer
// before release.
module strap_latch #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] strap_i,
    output logic             captured_o,
    output logic [WIDTH-1:0] strap_q_o
);

    logic             captured_q;
    logic [WIDTH-1:0] hold_q;

    // Clear on reset; take one snapshot on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            captured_q <= 1'b0;
            hold_q     <= '0;
        end else if (!captured_q) begin
            captured_q <= 1'b1;
            hold_q     <= strap_i;
        end
    end

    assign captured_o = captured_q;
    assign strap_q_o  = hold_q;

endmodule

// File: rtl/strap_decode.sv
// Module: strap_decode
// Turns the captured select and non-removable straps into mode flags,
// the slave address, the non-removable port mask and the per-port LED
// polarity. Assumes: inputs are already frozen; all flags stay low
// until valid_i is set.
module strap_decode
    import strap_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 valid_i,
    input  logic [CFG_SEL_W-1:0] sel_i,
    input  logic [NUM_PORTS-1:0] nonrem_i,
    output logic [CFG_SEL_W-1:0] src_o,
    output logic                 smbus_o,
    output logic                 default_o,
    output logic                 eeprom_o,
    output logic                 reserved_o,
    output logic [6:0]           addr_o,
    output logic [NUM_PORTS-1:0] nonrem_mask_o,
    output logic [NUM_PORTS-1:0] led_act_high_o
);

    cfg_src_e src;

    assign src   = cfg_src_e'(sel_i);
    assign src_o = sel_i;

    // Select code to a single mode flag, gated by capture.
    always_comb begin
        smbus_o    = 1'b0;
        default_o  = 1'b0;
        eeprom_o   = 1'b0;
        reserved_o = 1'b0;
        if (valid_i) begin
            unique case (src)
                CFG_SMBUS:   smbus_o    = 1'b1;
                CFG_DEFAULT: default_o  = 1'b1;
                CFG_EEPROM:  eeprom_o   = 1'b1;
                default:     reserved_o = 1'b1;
            endcase
        end
    end

    // Slave address is only meaningful in SMBus mode.
    always_comb begin
        addr_o = smbus_o ? SMBUS_SLAVE_ADDR : 7'd0;
    end

    // Thermometer port mask: port i is fixed when the strap value exceeds i.
    always_comb begin
        nonrem_mask_o = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            nonrem_mask_o[i] = default_o && (int'(nonrem_i) > i);
        end
    end

    // LED i is active high only in default mode with strap bit i clear.
    always_comb begin
        led_act_high_o = default_o ? ~nonrem_i : '0;
    end

endmodule

// File: rtl/pol_drive.sv
// Module: pol_drive
// Applies a per-port active level to request bits, or forces every port
// to a given idle level. Assumes: idle_i is chosen by the caller to be the
// inactive level for the outputs it drives.
module pol_drive #(
    parameter int NUM_PORTS = 2
) (
    input  logic                 force_idle_i,
    input  logic                 idle_i,
    input  logic [NUM_PORTS-1:0] act_high_i,
    input  logic [NUM_PORTS-1:0] req_i,
    output logic [NUM_PORTS-1:0] drive_o
);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            // Request at its active level, or the forced idle level.
            always_comb begin
                if (force_idle_i) begin
                    drive_o[p] = idle_i;
                end else begin
                    drive_o[p] = act_high_i[p] ? req_i[p] : ~req_i[p];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/strap_capture_ctrl.sv
// Module: strap_capture_ctrl (top)
// Captures configuration straps at reset release, decodes them, and drives
// the port power and LED pins at the strapped levels. Holds port power off
// from the live polarity strap until the capture. Reports local-supply
// status and the upstream connect request. Assumes: rst_n is synchronous to
// clk and held low for at least SYNC_STAGES cycles with stable straps.
module strap_capture_ctrl
    import strap_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_sel_strap_i,
    input  logic [NUM_PORTS-1:0] nonrem_strap_i,
    input  logic                 pwr_pol_strap_i,
    input  logic                 self_pwr_i,
    input  logic                 vbus_det_i,
    input  logic                 eeprom_absent_i,
    input  logic [NUM_PORTS-1:0] port_pwr_req_i,
    input  logic [NUM_PORTS-1:0] led_req_i,
    output logic [NUM_PORTS-1:0] port_pwr_o,
    output logic [NUM_PORTS-1:0] led_o,
    output logic                 cfg_valid_o,
    output logic [1:0]           cfg_src_o,
    output logic                 mode_smbus_o,
    output logic                 mode_default_o,
    output logic                 mode_eeprom_o,
    output logic                 mode_reserved_o,
    output logic [6:0]           smbus_addr_o,
    output logic [NUM_PORTS-1:0] nonrem_o,
    output logic                 cfg_zero_fill_o,
    output logic                 self_powered_o,
    output logic                 connect_req_o
);

    // Layout of the strap bundle: {sel, nonrem, pol}.
    localparam int STRAP_W = CFG_SEL_W + NUM_PORTS + 1;
    localparam int POL_LSB = 0;
    localparam int NR_LSB  = 1;
    localparam int SEL_LSB = NR_LSB + NUM_PORTS;
    // Sync bundle adds {self_pwr, vbus} above the straps.
    localparam int SYNC_W  = STRAP_W + 2;

    logic [SYNC_W-1:0]    sync_in;
    logic [SYNC_W-1:0]    sync_out;
    logic [STRAP_W-1:0]   strap_q;
    logic                 captured;
    logic                 hold_idle;
    logic                 pol_q;
    logic [NUM_PORTS-1:0] nr_q;
    logic [CFG_SEL_W-1:0] sel_q;
    logic [NUM_PORTS-1:0] led_act_high;
    logic [NUM_PORTS-1:0] pwr_act_high;

    assign sync_in = {self_pwr_i, vbus_det_i,
                      cfg_sel_strap_i, nonrem_strap_i, pwr_pol_strap_i};

    strap_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d_i (sync_in),
        .q_o (sync_out)
    );

    strap_latch #(
        .WIDTH (STRAP_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (sync_out[STRAP_W-1:0]),
        .captured_o (captured),
        .strap_q_o  (strap_q)
    );

    assign pol_q = strap_q[POL_LSB];
    assign nr_q  = strap_q[NR_LSB +: NUM_PORTS];
    assign sel_q = strap_q[SEL_LSB +: CFG_SEL_W];

    strap_decode #(
        .NUM_PORTS (NUM_PORTS)
    ) u_decode (
        .valid_i        (captured),
        .sel_i          (sel_q),
        .nonrem_i       (nr_q),
        .src_o          (cfg_src_o),
        .smbus_o        (mode_smbus_o),
        .default_o      (mode_default_o),
        .eeprom_o       (mode_eeprom_o),
        .reserved_o     (mode_reserved_o),
        .addr_o         (smbus_addr_o),
        .nonrem_mask_o  (nonrem_o),
        .led_act_high_o (led_act_high)
    );

    // Outputs stay idle from reset entry until the capture edge.
    assign hold_idle    = !rst_n || !captured;
    assign pwr_act_high = {NUM_PORTS{pol_q}};

    // Power idles at the inverse of the live polarity strap.
    pol_drive #(
        .NUM_PORTS (NUM_PORTS)
    ) u_pwr_drive (
        .force_idle_i (hold_idle),
        .idle_i       (~pwr_pol_strap_i),
        .act_high_i   (pwr_act_high),
        .req_i        (port_pwr_req_i),
        .drive_o      (port_pwr_o)
    );

    // LEDs idle high, the off level of the active-low default.
    pol_drive #(
        .NUM_PORTS (NUM_PORTS)
    ) u_led_drive (
        .force_idle_i (hold_idle),
        .idle_i       (1'b1),
        .act_high_i   (led_act_high),
        .req_i        (led_req_i),
        .drive_o      (led_o)
    );

    assign cfg_valid_o     = captured;
    assign cfg_zero_fill_o = mode_eeprom_o && eeprom_absent_i;
    assign self_powered_o  = sync_out[SYNC_W-1];
    assign connect_req_o   = captured && sync_out[SYNC_W-2];

endmodule

// File: rtl/strap_capture_chk.sv
// Module: strap_capture_chk
// Checker bound to strap_capture_ctrl; relates its ports over time.
module strap_capture_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwr_pol_strap_i,
    input logic                 eeprom_absent_i,
    input logic [NUM_PORTS-1:0] port_pwr_o,
    input logic [NUM_PORTS-1:0] led_o,
    input logic                 cfg_valid_o,
    input logic [1:0]           cfg_src_o,
    input logic                 mode_smbus_o,
    input logic                 mode_default_o,
    input logic                 mode_eeprom_o,
    input logic                 mode_reserved_o,
    input logic [6:0]           smbus_addr_o,
    input logic [NUM_PORTS-1:0] nonrem_o,
    input logic                 cfg_zero_fill_o,
    input logic                 connect_req_o
);

    // Reset-window checks sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            // R2
            pwr_idle_in_reset_chk:
                assert (port_pwr_o == {NUM_PORTS{~pwr_pol_strap_i}});
        end
        if (cfg_valid_o === 1'b0) begin
            // R8
            led_idle_before_capture_chk: assert (&led_o);
        end
    end

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |=> cfg_valid_o && $stable(cfg_src_o));

    // R4
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> $onehot({mode_smbus_o, mode_default_o,
                                 mode_eeprom_o, mode_reserved_o}));

    // R5
    smbus_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_smbus_o |-> smbus_addr_o == 7'b0101100);

    // R6
    nonrem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_default_o |-> nonrem_o == '0);

    // R9
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_zero_fill_o |-> mode_eeprom_o && eeprom_absent_i);

    // R11
    connect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        connect_req_o |-> cfg_valid_o);

    // R12
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |=> $stable({mode_smbus_o, mode_default_o,
                                 mode_eeprom_o, mode_reserved_o, nonrem_o}));

endmodule

bind strap_capture_ctrl strap_capture_chk #(
    .NUM_PORTS (NUM_PORTS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pwr_pol_strap_i (pwr_pol_strap_i),
    .eeprom_absent_i (eeprom_absent_i),
    .port_pwr_o      (port_pwr_o),
    .led_o           (led_o),
    .cfg_valid_o     (cfg_valid_o),
    .cfg_src_o       (cfg_src_o),
    .mode_smbus_o    (mode_smbus_o),
    .mode_default_o  (mode_default_o),
    .mode_eeprom_o   (mode_eeprom_o),
    .mode_reserved_o (mode_reserved_o),
    .smbus_addr_o    (smbus_addr_o),
    .nonrem_o        (nonrem_o),
    .cfg_zero_fill_o (cfg_zero_fill_o),
    .connect_req_o   (connect_req_o)
);

// File: tb/tb_strap_capture_ctrl.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them at the next falling clock edge.
module tb_strap_capture_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int SYNC       = 2;

    // Observed output selectors for scoreboard items.
    localparam int F_PWR    = 0;
    localparam int F_LED    = 1;
    localparam int F_VALID  = 2;
    localparam int F_SRC    = 3;
    localparam int F_MODES  = 4;
    localparam int F_ADDR   = 5;
    localparam int F_NONREM = 6;
    localparam int F_ZERO   = 7;
    localparam int F_SELF   = 8;
    localparam int F_CONN   = 9;

    typedef struct {
        int          field;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'b10;
    logic [NP-1:0] nr = '0;
    logic          pol = 1'b1;
    logic          self_pwr = 1'b0;
    logic          vbus = 1'b0;
    logic          ee_absent = 1'b0;
    logic [NP-1:0] pwr_req = '0;
    logic [NP-1:0] led_req = '0;
    logic [NP-1:0] port_pwr;
    logic [NP-1:0] led;
    logic          cfg_valid;
    logic [1:0]    cfg_src;
    logic          m_smbus, m_default, m_eeprom, m_reserved;
    logic [6:0]    addr;
    logic [NP-1:0] nonrem;
    logic          zero_fill;
    logic          self_powered;
    logic          connect;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_capture_ctrl #(
        .NUM_PORTS   (NP),
        .SYNC_STAGES (SYNC)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_sel_strap_i (sel),
        .nonrem_strap_i  (nr),
        .pwr_pol_strap_i (pol),
        .self_pwr_i      (self_pwr),
        .vbus_det_i      (vbus),
        .eeprom_absent_i (ee_absent),
        .port_pwr_req_i  (pwr_req),
        .led_req_i       (led_req),
        .port_pwr_o      (port_pwr),
        .led_o           (led),
        .cfg_valid_o     (cfg_valid),
        .cfg_src_o       (cfg_src),
        .mode_smbus_o    (m_smbus),
        .mode_default_o  (m_default),
        .mode_eeprom_o   (m_eeprom),
        .mode_reserved_o (m_reserved),
        .smbus_addr_o    (addr),
        .nonrem_o        (nonrem),
        .cfg_zero_fill_o (zero_fill),
        .self_powered_o  (self_powered),
        .connect_req_o   (connect)
    );

    function automatic logic [31:0] observe(int f);
        case (f)
            F_PWR:    return 32'(port_pwr);
            F_LED:    return 32'(led);
            F_VALID:  return 32'(cfg_valid);
            F_SRC:    return 32'(cfg_src);
            F_MODES:  return 32'({m_reserved, m_eeprom, m_default, m_smbus});
            F_ADDR:   return 32'(addr);
            F_NONREM: return 32'(nonrem);
            F_ZERO:   return 32'(zero_fill);
            F_SELF:   return 32'(self_powered);
            default:  return 32'(connect);
        endcase
    endfunction

    // Monitor: compare every queued item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = sb_q.pop_front();
                got = observe(it.field);
                n_tests++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s field %0d: actual %0h expected %0h",
                             it.tag, it.field, got, it.exp);
                end
            end
        end
    end

    task automatic push(int f, logic [31:0] e, string tag);
        item_t it;
        it.field = f;
        it.exp   = e;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Advance to just after the n-th next falling edge.
    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Expected level for a request under a given active-high mask.
    function automatic logic [NP-1:0] apply(logic [NP-1:0] req,
                                            logic [NP-1:0] ah);
        return ~(req ^ ah);
    endfunction

    function automatic logic [3:0] mode_bits(logic [1:0] s);
        case (s)
            2'b01:   return 4'b0001;
            2'b10:   return 4'b0010;
            2'b11:   return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [NP-1:0] nr_mask(logic [1:0] s, logic [NP-1:0] v);
        logic [NP-1:0] m;
        m = '0;
        if (s == 2'b10) begin
            for (int i = 0; i < NP; i++) m[i] = (int'(v) > i);
        end
        return m;
    endfunction

    // Reset with given straps, check the idle state, then release.
    task automatic do_reset(logic [1:0] s, logic [NP-1:0] v, logic p);
        rst_n = 1'b0;
        sel = s;
        nr  = v;
        pol = p;
        step(SYNC + 2);
        // R2: power idles at the inverse of the live polarity strap
        push(F_PWR, 32'({NP{~p}}), "R2");
        // R8: LEDs idle high before capture
        push(F_LED, 32'({NP{1'b1}}), "R8");
        // R1: not valid during reset
        push(F_VALID, 32'd0, "R1");
        // R11: no connect request during reset
        push(F_CONN, 32'd0, "R11");
        step(1);
        rst_n = 1'b1;
        // R1: valid right after the first edge out of reset
        push(F_VALID, 32'd1, "R1");
        step(1);
    endtask

    // Check decode results and polarities for every request pattern.
    task automatic check_cfg(logic [1:0] s, logic [NP-1:0] v, logic p);
        logic [NP-1:0] led_ah;
        led_ah = (s == 2'b10) ? ~v : '0;
        // R4
        push(F_SRC, 32'(s), "R4");
        push(F_MODES, 32'(mode_bits(s)), "R4");
        // R5
        push(F_ADDR, (s == 2'b01) ? 32'h2C : 32'd0, "R5");
        // R6
        push(F_NONREM, 32'(nr_mask(s, v)), "R6");
        step(1);
        for (int r = 0; r < (1 << NP); r++) begin
            pwr_req = NP'(r);
            led_req = NP'(r);
            // R3
            push(F_PWR, 32'(apply(NP'(r), {NP{p}})), "R3");
            // R7 / R8 polarity of LEDs
            push(F_LED, 32'(apply(NP'(r), led_ah)),
                 (s == 2'b10) ? "R7" : "R8");
            step(1);
        end
        pwr_req = '0;
        led_req = '0;
    endtask

    initial begin
        step(1);
        // R2: live polarity strap drives power idle during reset
        pol = 1'b1;
        #1;
        push(F_PWR, 32'({NP{1'b0}}), "R2");
        step(1);
        pol = 1'b0;
        #1;
        push(F_PWR, 32'({NP{1'b1}}), "R2");
        step(1);

        // Default mode, every non-removable code, both polarities.
        for (int v = 0; v < 4; v++) begin
            do_reset(2'b10, NP'(v), v[0]);
            check_cfg(2'b10, NP'(v), v[0]);
        end

        // SMBus mode with straps that would fix ports in default mode.
        do_reset(2'b01, 2'b11, 1'b0);
        check_cfg(2'b01, 2'b11, 1'b0);

        // Reserved code.
        do_reset(2'b00, 2'b01, 1'b1);
        check_cfg(2'b00, 2'b01, 1'b1);

        // EEPROM mode and zero fill.
        do_reset(2'b11, 2'b10, 1'b1);
        check_cfg(2'b11, 2'b10, 1'b1);
        ee_absent = 1'b1;
        // R9
        push(F_ZERO, 32'd1, "R9");
        step(1);
        ee_absent = 1'b0;
        push(F_ZERO, 32'd0, "R9");
        step(1);

        // R12: disturb straps after capture; nothing captured may move.
        sel = 2'b10;
        nr  = 2'b01;
        pol = 1'b0;
        step(SYNC + 3);
        pwr_req = 2'b01;
        led_req = 2'b01;
        push(F_SRC, 32'd3, "R12");
        push(F_MODES, 32'b0100, "R12");
        push(F_NONREM, 32'd0, "R12");
        push(F_PWR, 32'b01, "R12");
        push(F_LED, 32'b10, "R12");
        step(1);
        pwr_req = '0;
        led_req = '0;

        // R9: zero fill stays low outside EEPROM mode
        do_reset(2'b10, 2'b00, 1'b1);
        ee_absent = 1'b1;
        push(F_ZERO, 32'd0, "R9");
        step(1);
        ee_absent = 1'b0;

        // R10: self-power status latency
        step(SYNC + 1);
        self_pwr = 1'b1;
        for (int k = 1; k < SYNC; k++) begin
            push(F_SELF, 32'd0, "R10");
            step(1);
        end
        push(F_SELF, 32'd1, "R10");
        step(1);

        // R11: connect request latency after VBUS rises
        vbus = 1'b1;
        for (int k = 1; k < SYNC; k++) begin
            push(F_CONN, 32'd0, "R11");
            step(1);
        end
        push(F_CONN, 32'd1, "R11");
        step(1);
        vbus = 1'b0;
        step(SYNC);
        push(F_CONN, 32'd0, "R11");
        step(1);

        // R10: status keeps following the input inside reset
        rst_n = 1'b0;
        self_pwr = 1'b0;
        step(SYNC);
        push(F_SELF, 32'd0, "R10");
        step(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule